// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines from peripherals, resolves them by fixed priority, and raises one interrupt output toward the processor. When the processor acknowledges, the controller returns an 8-bit vector for the chosen source on the cycle after the acknowledge. It keeps an in-service set so that handlers can nest. A request of higher priority still reaches the processor while a handler runs. A request of equal or lower priority waits until the processor writes end-of-interrupt.

Software sets a 5-bit vector base and an 8-bit mask through a small write port. A third setting turns on cascade mode. In cascade mode, request line 2 is taken from a second controller's interrupt output. When line 2 is acknowledged, the acknowledge goes on to that controller and its vector is passed through. Two controllers joined this way give fifteen usable request lines.

The controller runs as a three-state machine:
- ST_IDLE: no interrupt is offered. It moves to ST_REQ when an eligible request exists.
- ST_REQ: the interrupt output is high. It moves to ST_VEC on an acknowledge. It falls back to ST_IDLE if the eligible request goes away first.
- ST_VEC: the vector is presented for one cycle, then the machine always returns to ST_IDLE.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset, int_o, vec_valid_o and slv_ack_o are low, the vector base and mask are zero, cascade mode is off and no line is in service.
- R2: A request that is unmasked and eligible, held on a line from a falling edge, raises int_o before the second falling edge after it.
- R3: Among pending eligible lines the lowest index wins, so line 0 has the highest priority and line 7 the lowest.
- R4: While int_o is high, an acknowledge makes vec_valid_o high for exactly one cycle on the next cycle, with vec_o = {base[4:0], line[2:0]}, and int_o is low in that cycle.
- R5: A line whose mask bit (cfg_sel=1, wdata bit n masks line n) is set never raises int_o. Clearing the mask bit lets it raise int_o.
- R6: An acknowledge marks the chosen line in service. While it is in service, that line and all lower-priority lines do not raise int_o.
- R7: A line of higher priority than every in-service line raises int_o even while other handlers are in service.
- R8: An end-of-interrupt pulse clears only the highest-priority in-service bit.
- R9: With cascade mode on (cfg_sel=2, wdata bit 0), line 2 follows slv_int_i instead of irq_req[2]. Acknowledging line 2 pulses slv_ack_o in the acknowledge cycle, and vec_o on the next cycle carries slv_vec_i.
- R10: If the eligible request is withdrawn before an acknowledge, int_o falls within two cycles and no vector is produced.
- R11: An acknowledge while int_o is low has no effect: no vector is produced and int_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Level request lines, index 0 highest priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Setting select: 0 base, 1 mask, 2 cascade enable |
| cfg_wdata | input | 8 | Write data (base in bits 4:0) |
| ack_i | input | 1 | Processor interrupt acknowledge |
| eoi_i | input | 1 | End-of-interrupt pulse |
| slv_int_i | input | 1 | Interrupt output of a cascaded controller |
| slv_vec_i | input | 8 | Vector from the cascaded controller |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector on vec_o is valid |
| vec_o | output | 8 | Interrupt vector |
| slv_ack_o | output | 1 | Acknowledge passed to the cascaded controller |

## Verification
A corrupted in-service set shows up at the ports as a missing or unexpected int_o within two cycles of the next request or end-of-interrupt. In the nested sequence, an end-of-interrupt that clears the wrong bit releases a blocked lower-priority line too early. A stale or wrong latched selection appears as a wrong vector in the single cycle after the acknowledge. The scoreboard catches that cycle, and it also catches a vector that arrives with no acknowledge behind it. A machine stuck in ST_REQ or ST_VEC holds int_o or vec_valid_o past the cycle in which the bench samples it.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NLINES = 8;
    localparam int LW     = $clog2(NLINES);
    localparam int VW     = 8;
    localparam int BW     = VW - LW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_VEC  = 2'd2
    } vic_state_e;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_MASK = 2'd1,
        CFG_CASC = 2'd2
    } vic_cfg_e;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                valid = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int N   = NLINES,
    parameter int BWD = BW,
    parameter int DW  = VW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [1:0]     sel,
    input  logic [DW-1:0]  wdata,
    output logic [BWD-1:0] base,
    output logic [N-1:0]   mask,
    output logic           casc_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            mask    <= '0;
            casc_en <= 1'b0;
        end else if (we) begin
            unique case (vic_cfg_e'(sel))
                CFG_BASE: base    <= wdata[BWD-1:0];
                CFG_MASK: mask    <= wdata[N-1:0];
                CFG_CASC: casc_en <= wdata[0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/vic_isr_reg.sv
module vic_isr_reg #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [W-1:0] set_idx,
    input  logic         eoi,
    output logic [N-1:0] isr,
    output logic         top_valid,
    output logic [W-1:0] top_idx
);
    logic [N-1:0] isr_nxt;

    vic_prio_enc #(.N(N), .W(W)) top_enc_i (
        .bits  (isr),
        .valid (top_valid),
        .idx   (top_idx)
    );

    always_comb begin
        isr_nxt = isr;
        if (eoi && top_valid) isr_nxt[top_idx] = 1'b0;
        if (set_en)           isr_nxt[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= isr_nxt;
    end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
    import vic_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_req,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [VW-1:0]     cfg_wdata,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              slv_int_i,
    input  logic [VW-1:0]     slv_vec_i,
    output logic              int_o,
    output logic              vec_valid_o,
    output logic [VW-1:0]     vec_o,
    output logic              slv_ack_o
);
    localparam logic [LW-1:0] CASC_IDX = LW'(CASC_LINE);

    vic_state_e        state_q, state_d;
    logic [BW-1:0]     base_w;
    logic [NLINES-1:0] mask_w;
    logic              casc_w;
    logic [NLINES-1:0] req_eff, irr_q, pend_w, isr_w;
    logic              cand_v, isr_top_v, cand_ok, take;
    logic [LW-1:0]     cand_idx, isr_top_idx;
    logic [VW-1:0]     vec_q;
    logic              casc_sel_q, take_casc;

    vic_cfg_regs #(.N(NLINES), .BWD(BW), .DW(VW)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .base    (base_w),
        .mask    (mask_w),
        .casc_en (casc_w)
    );

    // Line CASC_LINE is fed by the second controller in cascade mode.
    always_comb begin
        req_eff = irq_req;
        if (casc_w) req_eff[CASC_LINE] = slv_int_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= req_eff;
    end

    assign pend_w = irr_q & ~mask_w;

    vic_prio_enc #(.N(NLINES), .W(LW)) cand_enc_i (
        .bits  (pend_w),
        .valid (cand_v),
        .idx   (cand_idx)
    );

    vic_isr_reg #(.N(NLINES), .W(LW)) isr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (take),
        .set_idx   (cand_idx),
        .eoi       (eoi_i),
        .isr       (isr_w),
        .top_valid (isr_top_v),
        .top_idx   (isr_top_idx)
    );

    // A candidate is offered only when it outranks every in-service line.
    assign cand_ok   = cand_v && (!isr_top_v || (cand_idx < isr_top_idx));
    assign take      = (state_q == ST_REQ) && ack_i && cand_ok;
    assign take_casc = take && casc_w && (cand_idx == CASC_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cand_ok) state_d = ST_REQ;
            ST_REQ: begin
                if (take)          state_d = ST_VEC;
                else if (!cand_ok) state_d = ST_IDLE;
            end
            ST_VEC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            vec_q      <= '0;
            casc_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                vec_q      <= {base_w, cand_idx};
                casc_sel_q <= take_casc;
            end
        end
    end

    always_comb begin
        int_o       = 1'b0;
        vec_valid_o = 1'b0;
        vec_o       = '0;
        slv_ack_o   = take_casc;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  int_o = 1'b1;
            ST_VEC: begin
                vec_valid_o = 1'b1;
                vec_o       = casc_sel_q ? slv_vec_i : vec_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vic_irq_ctrl_chk.sv
module vic_irq_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack_i,
    input logic         eoi_i,
    input logic         int_o,
    input logic         vec_valid_o,
    input logic         slv_ack_o,
    input logic [N-1:0] pend,
    input logic [N-1:0] isr
);
    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o); // R4
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(int_o && ack_i)); // R11
    AST_INT_VEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_o && vec_valid_o)); // R4
    AST_INT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(|pend)); // R5
    AST_SLV_ACK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack_o |-> (ack_i && int_o)); // R9
    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(int_o && ack_i) && (|isr)) |=>
            ($countones(isr) == $past($countones(isr)) - 1)); // R8
    AST_VEC_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !$past(eoi_i)) |->
            ($countones(isr) == $past($countones(isr)) + 1)); // R6
endmodule

bind vic_irq_ctrl vic_irq_ctrl_chk #(.N(vic_pkg::NLINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .eoi_i       (eoi_i),
    .int_o       (int_o),
    .vec_valid_o (vec_valid_o),
    .slv_ack_o   (slv_ack_o),
    .pend        (pend_w),
    .isr         (isr_w)
);

// File: tb/vic_irq_ctrl_tb.sv
module vic_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ack_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       slv_int_i = 1'b0;
    logic [7:0] slv_vec_i = '0;
    logic       int_o, vec_valid_o, slv_ack_o;
    logic [7:0] vec_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      exp_tag[$];

    always #4 clk = ~clk;

    vic_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack_i(ack_i), .eoi_i(eoi_i),
        .slv_int_i(slv_int_i), .slv_vec_i(slv_vec_i), .int_o(int_o),
        .vec_valid_o(vec_valid_o), .vec_o(vec_o), .slv_ack_o(slv_ack_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every produced vector must match the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && vec_valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11 actual=%0h expected=none", vec_o);
            end else begin
                check(exp_tag.pop_front(), {24'd0, vec_o}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_int(input string req);
        int k;
        for (k = 0; k < 10 && !int_o; k++) @(negedge clk);
        check(req, {31'd0, int_o}, 32'd1);
    endtask

    // Driver: push expected vector, then acknowledge for one cycle.
    task automatic ack_expect(input string req, input logic [7:0] v);
        exp_q.push_back(v);
        exp_tag.push_back(req);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        check("R4 int low with vector", {31'd0, int_o}, 32'd0);
        @(negedge clk);
    endtask

    task automatic eoi();
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 int", {31'd0, int_o}, 0);
        check("R1 vec_valid", {31'd0, vec_valid_o}, 0);
        check("R1 slv_ack", {31'd0, slv_ack_o}, 0);
        // Reset base is zero: first vector with line 6 must be 0x06.
        irq_req = 8'h40;
        wait_cycles(2);
        check("R2 int after request", {31'd0, int_o}, 1);
        ack_expect("R1 base zero", 8'h06);
        irq_req = 8'h00;
        eoi();

        cfg(2'd0, 8'h0A);
        // Hold line 5: acknowledged, then blocked while in service.
        irq_req = 8'h20;
        wait_cycles(1);
        check("R2 not before second edge", {31'd0, int_o}, 0);
        wait_cycles(1);
        check("R2 int", {31'd0, int_o}, 1);
        ack_expect("R4 vector line5", 8'h55);
        wait_cycles(4);
        check("R6 same line blocked", {31'd0, int_o}, 0);
        eoi();
        wait_int("R8 eoi releases line5");
        ack_expect("R4 vector line5 again", 8'h55);
        irq_req = 8'h00;
        eoi();

        // Withdrawn request.
        irq_req = 8'h10;
        wait_int("R10 int raised");
        irq_req = 8'h00;
        wait_cycles(2);
        check("R10 int dropped", {31'd0, int_o}, 0);

        // Priority and nesting.
        irq_req = 8'hC8;
        wait_int("R3 int");
        ack_expect("R3 lowest index wins", 8'h53);
        wait_cycles(3);
        check("R6 lower lines blocked", {31'd0, int_o}, 0);
        irq_req = 8'hCA;
        wait_int("R7 higher preempts");
        ack_expect("R7 vector line1", 8'h51);
        irq_req = 8'hC0;
        eoi();
        wait_cycles(3);
        check("R8 only top bit cleared", {31'd0, int_o}, 0);
        eoi();
        wait_int("R8 second eoi releases line6");
        ack_expect("R3 line6 after 7", 8'h56);
        irq_req = 8'h00;
        eoi();

        // Mask.
        cfg(2'd1, 8'h10);
        irq_req = 8'h10;
        wait_cycles(4);
        check("R5 masked line quiet", {31'd0, int_o}, 0);
        cfg(2'd1, 8'h00);
        wait_int("R5 unmasked raises");
        ack_expect("R5 vector line4", 8'h54);
        irq_req = 8'h00;
        eoi();

        // Acknowledge with nothing offered.
        wait_cycles(2);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        @(negedge clk);
        check("R11 no vector", {31'd0, vec_valid_o}, 0);
        check("R11 int stays low", {31'd0, int_o}, 0);

        // Cascade on line 2.
        cfg(2'd2, 8'h01);
        slv_vec_i = 8'hA3;
        irq_req = 8'h04;
        wait_cycles(4);
        check("R9 own line2 ignored", {31'd0, int_o}, 0);
        irq_req = 8'h00;
        slv_int_i = 1'b1;
        wait_int("R9 slave raises");
        exp_q.push_back(8'hA3);
        exp_tag.push_back("R9 slave vector");
        ack_i = 1'b1;
        #1;
        check("R9 slave ack", {31'd0, slv_ack_o}, 1);
        @(negedge clk);
        ack_i = 1'b0;
        #1;
        check("R9 slave ack one cycle", {31'd0, slv_ack_o}, 0);
        @(negedge clk);
        slv_int_i = 1'b0;
        eoi();
        wait_cycles(3);

        check("scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule